// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block gathers 64 level-type interrupt sources and presents them to a processor as two request lines: a normal request and a fast request. Each source has a pending bit, an enable bit, a type bit that routes it to the fast line, and a 4-bit priority. A 5-bit mask sets the priority a normal source must exceed before the normal line is raised. The all-ones mask value is the exception: it lets any active normal source through.

Software reaches the state through a simple word-indexed register bus. The bus has an index, a write strobe, a read strobe, 32-bit write data and combinational 32-bit read data. Two vector status words report the winning normal source and the winning fast source. Reading one of these words acknowledges the source it reports, which clears that source's pending bit at the clock edge that ends the read. Sources can also be enabled or disabled one at a time by number. Force registers overwrite the pending bits directly.

An edge on a source's level input sets its pending bit on a rise and clears it on a fall. The change lands at the next clock edge. The active-low reset is asserted asynchronously and released through a two-stage synchronizer.

Top module: `vec_intc`

## Requirements
- R1: After reset, the following are all zero: pending, enable, type, control and every priority. The mask reads 0x1F, both request outputs are low, and both vector words (index 16 and 17) read 0xFFFFFFFF.
- R2: Control (index 0) stores only bits [5:0] of a write, and every other bit reads 0. When bit 0 is set, a 1 written in bit 6 clears bit 6, so bit 6 always reads 0.
- R3: The mask (index 1) keeps bits [4:0] of a write.
- R4: A write to index 2 sets enable bit wdata[5:0]. A write to index 3 clears enable bit wdata[5:0]. The higher data bits are ignored, and both indexes read 0.
- R5: Enable bits [63:32] are at index 4 and bits [31:0] at index 5. Type bits [63:32] are at index 6 and bits [31:0] at index 7. A type bit of 1 makes the source fast. Each of these indexes is read/write.
- R6: Index i in 8..15 holds priority word 15-i. Source s takes its priority from word s/8, bits [4*(s%8)+3 : 4*(s%8)].
- R7: A rising level input sets that source's pending bit, and a falling one clears it, at the next clock edge. Pending bits [63:32] read at index 18 and bits [31:0] at index 19, and writes to these indexes are ignored.
- R8: A write to index 20 replaces pending [63:32], and a write to index 21 replaces pending [31:0]. If a level edge falls in the same cycle, the write wins. Both indexes read 0.
- R9: Active bits are pending AND enable. The normal active bits (type 0) read at index 22 (upper half) and 23 (lower half). The fast active bits read at index 24 (upper half) and 25 (lower half). Index 64 reads 4, and any other unlisted index reads 0.
- R10: A read of index 16 returns (source<<16)|priority for the active normal source with the highest priority, taking the highest source number on a tie. The read clears that source's pending bit. With no active normal source, the read returns 0xFFFFFFFF.
- R11: A read of index 17 returns the lowest-numbered active fast source and clears its pending bit. With no active fast source, the read returns 0xFFFFFFFF.
- R12: The fast output is high exactly when at least one fast source is active.
- R13: The normal output is high when a normal source is active and either the mask is 0x1F or some active normal priority is greater than the mask.
- R14: When a vector read acknowledges a source in the same cycle that the source's level input rises, the pending bit ends cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_lvl_i | input | 64 | Per-source interrupt levels |
| bus_idx_i | input | 10 | Register index (byte offset / 4) |
| bus_we_i | input | 1 | Write strobe |
| bus_re_i | input | 1 | Read strobe; qualifies vector acknowledges |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for the current index |
| irq_norm_o | output | 1 | Normal interrupt request |
| irq_fast_o | output | 1 | Fast interrupt request |

## Verification
A vector-read acknowledge and a level-input edge can both target the same pending bit in one clock. To provoke the collision, the bench raises the level of a forced-pending source on the very cycle that it reads the normal vector. It also raises a neighbouring source in that cycle, so the clearing is shown to stay confined to the acknowledged bit. The outcome is judged from the raw pending word read afterwards: the acknowledged bit must be clear and the neighbour's bit set. Separate sweeps drain full pending patterns through both vector words and walk every mask value against every priority.

// File: rtl/vec_intc_pkg.sv
package vec_intc_pkg;
  localparam int unsigned SRC_N = 64;
  localparam int unsigned PRI_W = 4;
  localparam int unsigned MSK_W = 5;
  localparam int unsigned DAT_W = 32;

  // register indexes (byte offset / 4)
  localparam int unsigned IX_CTRL    = 0;
  localparam int unsigned IX_MASK    = 1;
  localparam int unsigned IX_ENNUM   = 2;
  localparam int unsigned IX_DISNUM  = 3;
  localparam int unsigned IX_EN_HI   = 4;
  localparam int unsigned IX_EN_LO   = 5;
  localparam int unsigned IX_TY_HI   = 6;
  localparam int unsigned IX_TY_LO   = 7;
  localparam int unsigned IX_PRI_LO  = 8;
  localparam int unsigned IX_PRI_HI  = 15;
  localparam int unsigned IX_NVEC    = 16;
  localparam int unsigned IX_FVEC    = 17;
  localparam int unsigned IX_PND_HI  = 18;
  localparam int unsigned IX_PND_LO  = 19;
  localparam int unsigned IX_FRC_HI  = 20;
  localparam int unsigned IX_FRC_LO  = 21;
  localparam int unsigned IX_NACT_HI = 22;
  localparam int unsigned IX_NACT_LO = 23;
  localparam int unsigned IX_FACT_HI = 24;
  localparam int unsigned IX_FACT_LO = 25;
  localparam int unsigned IX_CONST   = 64;

  localparam logic [DAT_W-1:0] CONST_WORD = 32'd4;
  localparam logic [DAT_W-1:0] VEC_NONE   = 32'hFFFF_FFFF;
  localparam logic [DAT_W-1:0] CTRL_KEEP  = 32'h0000_003F;
  localparam int unsigned      CTRL_FLAG    = 6;
  localparam int unsigned      CTRL_FLAG_EN = 0;
endpackage

// File: rtl/vec_intc_edge.sv
module vec_intc_edge #(
  parameter int unsigned N = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  logic [N-1:0] lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= '0;
    else        lvl_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~lvl_q;
  assign fall_o = ~lvl_i & lvl_q;
endmodule

// File: rtl/vec_intc_prio.sv
// Highest priority wins; on equal priority the higher index wins.
module vec_intc_prio #(
  parameter int unsigned N  = 64,
  parameter int unsigned PW = 4,
  parameter int unsigned IW = 6
) (
  input  logic [N-1:0]    act_i,
  input  logic [N*PW-1:0] prio_i,
  output logic            found_o,
  output logic [IW-1:0]   idx_o,
  output logic [PW-1:0]   prio_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    prio_o  = '0;
    for (int i = 0; i < N; i++) begin
      if (act_i[i] && (!found_o || prio_i[i*PW +: PW] >= prio_o)) begin
        found_o = 1'b1;
        idx_o   = IW'(i);
        prio_o  = prio_i[i*PW +: PW];
      end
    end
  end
endmodule

// File: rtl/vec_intc_first.sv
// Lowest set index of an activity vector.
module vec_intc_first #(
  parameter int unsigned N  = 64,
  parameter int unsigned IW = 6
) (
  input  logic [N-1:0]  act_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (act_i[i]) begin
        found_o = 1'b1;
        idx_o   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/vec_intc.sv
module vec_intc
  import vec_intc_pkg::*;
#(
  parameter int unsigned NSRC = SRC_N,
  parameter int unsigned AW   = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  src_lvl_i,
  input  logic [AW-1:0]    bus_idx_i,
  input  logic             bus_we_i,
  input  logic             bus_re_i,
  input  logic [DAT_W-1:0] bus_wdata_i,
  output logic [DAT_W-1:0] bus_rdata_o,
  output logic             irq_norm_o,
  output logic             irq_fast_o
);
  localparam int unsigned HALF     = NSRC / 2;
  localparam int unsigned SW       = $clog2(NSRC);
  localparam int unsigned PER_WORD = DAT_W / PRI_W;
  localparam int unsigned NWORD    = NSRC / PER_WORD;
  localparam int unsigned WSW      = $clog2(NWORD);

  // ---------------- reset release synchronizer ----------------
  logic [1:0] rs_q;
  logic       rst_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_ok = rs_q[1];

  function automatic logic at(input logic [AW-1:0] a, input int unsigned ix);
    return a == AW'(ix);
  endfunction

  // ---------------- state ----------------
  logic [DAT_W-1:0]  ctrl_q, ctrl_d;
  logic [MSK_W-1:0]  mask_q;
  logic [NSRC-1:0]   en_q, en_d, type_q, type_d, pend_q, pend_d;
  logic [DAT_W-1:0]  prio_w [NWORD];
  logic [NSRC*PRI_W-1:0] prio_flat;

  // ---------------- level edges ----------------
  logic [NSRC-1:0] lvl_rise, lvl_fall;
  vec_intc_edge #(.N(NSRC)) u_edge (
    .clk    (clk),
    .rst_n  (rst_ok),
    .lvl_i  (src_lvl_i),
    .rise_o (lvl_rise),
    .fall_o (lvl_fall)
  );

  // ---------------- selection ----------------
  logic [NSRC-1:0]  act_n, act_f;
  logic             n_found, f_found;
  logic [SW-1:0]    n_idx, f_idx;
  logic [PRI_W-1:0] n_prio;

  assign act_n = pend_q & en_q & ~type_q;
  assign act_f = pend_q & en_q & type_q;

  vec_intc_prio #(.N(NSRC), .PW(PRI_W), .IW(SW)) u_npick (
    .act_i   (act_n),
    .prio_i  (prio_flat),
    .found_o (n_found),
    .idx_o   (n_idx),
    .prio_o  (n_prio)
  );

  vec_intc_first #(.N(NSRC), .IW(SW)) u_fpick (
    .act_i   (act_f),
    .found_o (f_found),
    .idx_o   (f_idx)
  );

  // ---------------- decode / clock enables ----------------
  logic ctrl_we, mask_we, en_we, ty_we, prio_we, frc_hi, frc_lo;
  logic n_ack, f_ack, in_prio;
  logic [WSW-1:0] pw_sel;

  assign in_prio = (bus_idx_i >= AW'(IX_PRI_LO)) && (bus_idx_i <= AW'(IX_PRI_HI));
  assign pw_sel  = WSW'(IX_PRI_HI - 32'(bus_idx_i));
  assign ctrl_we = bus_we_i && at(bus_idx_i, IX_CTRL);
  assign mask_we = bus_we_i && at(bus_idx_i, IX_MASK);
  assign en_we   = bus_we_i && (at(bus_idx_i, IX_ENNUM) || at(bus_idx_i, IX_DISNUM) ||
                                at(bus_idx_i, IX_EN_HI) || at(bus_idx_i, IX_EN_LO));
  assign ty_we   = bus_we_i && (at(bus_idx_i, IX_TY_HI) || at(bus_idx_i, IX_TY_LO));
  assign prio_we = bus_we_i && in_prio;
  assign frc_hi  = bus_we_i && at(bus_idx_i, IX_FRC_HI);
  assign frc_lo  = bus_we_i && at(bus_idx_i, IX_FRC_LO);
  assign n_ack   = bus_re_i && at(bus_idx_i, IX_NVEC) && n_found;
  assign f_ack   = bus_re_i && at(bus_idx_i, IX_FVEC) && f_found;

  // ---------------- next state ----------------
  always_comb begin
    ctrl_d = bus_wdata_i & CTRL_KEEP;
    if (ctrl_d[CTRL_FLAG_EN] && bus_wdata_i[CTRL_FLAG]) ctrl_d[CTRL_FLAG] = 1'b0;
  end

  always_comb begin
    en_d = en_q;
    if (at(bus_idx_i, IX_ENNUM))  en_d[bus_wdata_i[SW-1:0]] = 1'b1;
    if (at(bus_idx_i, IX_DISNUM)) en_d[bus_wdata_i[SW-1:0]] = 1'b0;
    if (at(bus_idx_i, IX_EN_HI))  en_d[NSRC-1:HALF] = bus_wdata_i;
    if (at(bus_idx_i, IX_EN_LO))  en_d[HALF-1:0]    = bus_wdata_i;
  end

  always_comb begin
    type_d = type_q;
    if (at(bus_idx_i, IX_TY_HI)) type_d[NSRC-1:HALF] = bus_wdata_i;
    if (at(bus_idx_i, IX_TY_LO)) type_d[HALF-1:0]    = bus_wdata_i;
  end

  // level edges, then force overwrite, then acknowledges (strongest)
  always_comb begin
    pend_d = (pend_q | lvl_rise) & ~lvl_fall;
    if (frc_hi) pend_d[NSRC-1:HALF] = bus_wdata_i;
    if (frc_lo) pend_d[HALF-1:0]    = bus_wdata_i;
    if (n_ack)  pend_d[n_idx] = 1'b0;
    if (f_ack)  pend_d[f_idx] = 1'b0;
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      ctrl_q <= '0;
      mask_q <= '1;
      en_q   <= '0;
      type_q <= '0;
      pend_q <= '0;
    end else begin
      if (ctrl_we) ctrl_q <= ctrl_d;
      if (mask_we) mask_q <= bus_wdata_i[MSK_W-1:0];
      if (en_we)   en_q   <= en_d;
      if (ty_we)   type_q <= type_d;
      pend_q <= pend_d;
    end
  end

  for (genvar w = 0; w < NWORD; w++) begin : g_pw
    logic we_w;
    assign we_w = prio_we && (pw_sel == WSW'(w));
    always_ff @(posedge clk or negedge rst_ok) begin
      if (!rst_ok)   prio_w[w] <= '0;
      else if (we_w) prio_w[w] <= bus_wdata_i;
    end
    assign prio_flat[w*DAT_W +: DAT_W] = prio_w[w];
  end

  // ---------------- read mux ----------------
  always_comb begin
    bus_rdata_o = '0;
    case (bus_idx_i)
      AW'(IX_CTRL):    bus_rdata_o = ctrl_q;
      AW'(IX_MASK):    bus_rdata_o = DAT_W'(mask_q);
      AW'(IX_EN_HI):   bus_rdata_o = en_q[NSRC-1:HALF];
      AW'(IX_EN_LO):   bus_rdata_o = en_q[HALF-1:0];
      AW'(IX_TY_HI):   bus_rdata_o = type_q[NSRC-1:HALF];
      AW'(IX_TY_LO):   bus_rdata_o = type_q[HALF-1:0];
      AW'(IX_NVEC):    bus_rdata_o = n_found ? ((DAT_W'(n_idx) << 16) | DAT_W'(n_prio)) : VEC_NONE;
      AW'(IX_FVEC):    bus_rdata_o = f_found ? DAT_W'(f_idx) : VEC_NONE;
      AW'(IX_PND_HI):  bus_rdata_o = pend_q[NSRC-1:HALF];
      AW'(IX_PND_LO):  bus_rdata_o = pend_q[HALF-1:0];
      AW'(IX_NACT_HI): bus_rdata_o = act_n[NSRC-1:HALF];
      AW'(IX_NACT_LO): bus_rdata_o = act_n[HALF-1:0];
      AW'(IX_FACT_HI): bus_rdata_o = act_f[NSRC-1:HALF];
      AW'(IX_FACT_LO): bus_rdata_o = act_f[HALF-1:0];
      AW'(IX_CONST):   bus_rdata_o = CONST_WORD;
      default:         if (in_prio) bus_rdata_o = prio_w[pw_sel];
    endcase
  end

  // ---------------- requests ----------------
  assign irq_fast_o = f_found;
  assign irq_norm_o = n_found && ((&mask_q) || ({1'b0, n_prio} > mask_q));
endmodule

// File: rtl/vec_intc_chk.sv
module vec_intc_chk #(
  parameter int unsigned NSRC = 64,
  parameter int unsigned AW   = 10
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [AW-1:0]           idx_i,
  input logic                    we_i,
  input logic                    re_i,
  input logic [$clog2(NSRC)-1:0] wsrc_i,
  input logic [31:0]             rdata_i,
  input logic [NSRC-1:0]         en_i,
  input logic [NSRC-1:0]         pend_i,
  input logic [NSRC-1:0]         ty_i
);
  localparam int unsigned SW = $clog2(NSRC);

  // R4: enable-by-number sets the addressed bit
  p_en_num_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && idx_i == AW'(2)) |=> en_i[$past(wsrc_i)]);

  // R4: disable-by-number clears the addressed bit
  p_dis_num_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && idx_i == AW'(3)) |=> !en_i[$past(wsrc_i)]);

  // R10: a reported normal source is acknowledged
  p_nvec_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (re_i && !we_i && idx_i == AW'(16) && rdata_i != 32'hFFFF_FFFF)
      |=> !pend_i[$past(rdata_i[16 +: SW])]);

  // R10: no active normal source reads as all ones
  p_nvec_none_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (re_i && idx_i == AW'(16) && (pend_i & en_i & ~ty_i) == '0) |-> rdata_i == 32'hFFFF_FFFF);

  // R11: a reported fast source is acknowledged
  p_fvec_ack_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (re_i && !we_i && idx_i == AW'(17) && rdata_i != 32'hFFFF_FFFF)
      |=> !pend_i[$past(rdata_i[SW-1:0])]);

  // R11: no active fast source reads as all ones
  p_fvec_none_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (re_i && idx_i == AW'(17) && (pend_i & en_i & ty_i) == '0) |-> rdata_i == 32'hFFFF_FFFF);
endmodule

bind vec_intc vec_intc_chk #(.NSRC(NSRC), .AW(AW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_ok),
  .idx_i   (bus_idx_i),
  .we_i    (bus_we_i),
  .re_i    (bus_re_i),
  .wsrc_i  (bus_wdata_i[SW-1:0]),
  .rdata_i (bus_rdata_o),
  .en_i    (en_q),
  .pend_i  (pend_q),
  .ty_i    (type_q)
);

// File: tb/tb_vec_intc.sv
module tb_vec_intc;
  localparam logic [31:0] NONE = 32'hFFFF_FFFF;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] lvl;
  logic [9:0]  idx;
  logic        we, re;
  logic [31:0] wd, rdata;
  logic        irq_n, irq_f;

  int n_chk = 0;
  int n_fail = 0;

  logic [63:0] m_pend, m_en, m_ty;
  logic [3:0]  m_pr [64];

  always #5 clk = ~clk;

  vec_intc dut (
    .clk(clk), .rst_n(rst_n), .src_lvl_i(lvl), .bus_idx_i(idx),
    .bus_we_i(we), .bus_re_i(re), .bus_wdata_i(wd), .bus_rdata_o(rdata),
    .irq_norm_o(irq_n), .irq_fast_o(irq_f)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input int ix, input logic [31:0] d);
    @(negedge clk);
    idx = 10'(ix); we = 1'b1; wd = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input int ix, output logic [31:0] d);
    @(negedge clk);
    idx = 10'(ix); re = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    re = 1'b0;
  endtask

  task automatic rdchk(input string req, input int ix, input logic [31:0] exp);
    logic [31:0] g;
    rd(ix, g);
    chk(req, g, exp);
  endtask

  function automatic logic [31:0] exp_nvec();
    int best = -1;
    int who = -1;
    for (int s = 63; s >= 0; s--)
      if (m_pend[s] && m_en[s] && !m_ty[s] && int'(m_pr[s]) > best) begin
        best = int'(m_pr[s]);
        who = s;
      end
    if (who < 0) return NONE;
    return (32'(who) << 16) | 32'(best);
  endfunction

  function automatic logic [31:0] exp_fvec();
    for (int s = 0; s < 64; s++)
      if (m_pend[s] && m_en[s] && m_ty[s]) return 32'(s);
    return NONE;
  endfunction

  task automatic set_pend(input logic [63:0] p);
    wr(20, p[63:32]); wr(21, p[31:0]); m_pend = p;
  endtask

  task automatic set_en(input logic [63:0] p);
    wr(4, p[63:32]); wr(5, p[31:0]); m_en = p;
  endtask

  task automatic set_ty(input logic [63:0] p);
    wr(6, p[63:32]); wr(7, p[31:0]); m_ty = p;
  endtask

  function automatic logic [31:0] pword(input int w);
    logic [31:0] v = '0;
    for (int k = 0; k < 8; k++) v[4*k +: 4] = m_pr[8*w + k];
    return v;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] g, e;
    rst_n = 1'b0; lvl = '0; idx = '0; we = 1'b0; re = 1'b0; wd = '0;
    m_pend = '0; m_en = '0; m_ty = '0;
    for (int s = 0; s < 64; s++) m_pr[s] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 irq_norm", 32'(irq_n), 0);
    chk("R1 irq_fast", 32'(irq_f), 0);
    rdchk("R1 ctrl", 0, 0);
    rdchk("R1 mask", 1, 32'h1F);
    for (int ix = 4; ix <= 15; ix++) rdchk("R1 en/type/prio", ix, 0);
    rdchk("R1 nvec", 16, NONE);
    rdchk("R1 fvec", 17, NONE);
    rdchk("R1 pend hi", 18, 0);
    rdchk("R1 pend lo", 19, 0);

    // R2 control
    wr(0, 32'hFFFF_FFFF); rdchk("R2 keep bits", 0, 32'h3F);
    wr(0, 32'h0000_0041); rdchk("R2 flag clear", 0, 32'h01);
    wr(0, 32'h0000_0040); rdchk("R2 flag only", 0, 32'h00);
    wr(0, 0);

    // R3 mask
    wr(1, 32'hFFFF_FFE5); rdchk("R3 mask width", 1, 32'h05);
    wr(1, 32'h1F);        rdchk("R3 mask back", 1, 32'h1F);

    // R4 enable / disable by number, junk in upper data bits
    for (int n = 0; n < 64; n++) begin
      wr(2, 32'hA5A5_A5C0 | 32'(n)); m_en[n] = 1'b1;
      rdchk("R4 enable lo", 5, m_en[31:0]);
      rdchk("R4 enable hi", 4, m_en[63:32]);
    end
    rdchk("R4 index2 reads 0", 2, 0);
    rdchk("R4 index3 reads 0", 3, 0);
    for (int n = 63; n >= 0; n -= 3) begin
      wr(3, 32'h5A5A_5A40 | 32'(n)); m_en[n] = 1'b0;
      rdchk("R4 disable lo", 5, m_en[31:0]);
      rdchk("R4 disable hi", 4, m_en[63:32]);
    end

    // R5 halves
    set_en(64'h9ABC_DEF0_1234_5678);
    rdchk("R5 en hi", 4, 32'h9ABC_DEF0);
    rdchk("R5 en lo", 5, 32'h1234_5678);
    set_ty(64'h0F1E_2D3C_8070_6050);
    rdchk("R5 type hi", 6, 32'h0F1E_2D3C);
    rdchk("R5 type lo", 7, 32'h8070_6050);

    // R6 priority words
    for (int s = 0; s < 64; s++) m_pr[s] = 4'((s * 7 + 3) % 16);
    for (int w = 0; w < 8; w++) wr(15 - w, pword(w));
    for (int ix = 8; ix <= 15; ix++) rdchk("R6 prio word", ix, pword(15 - ix));

    // R7 level edges
    @(negedge clk); lvl = 64'h0000_0F00_8000_0001; m_pend = lvl;
    rdchk("R7 rise lo", 19, m_pend[31:0]);
    rdchk("R7 rise hi", 18, m_pend[63:32]);
    @(negedge clk); lvl = 64'h0000_0300_0000_0001; m_pend = lvl;
    rdchk("R7 fall lo", 19, m_pend[31:0]);
    rdchk("R7 fall hi", 18, m_pend[63:32]);
    wr(18, 32'hFFFF_FFFF); wr(19, 32'hFFFF_FFFF);
    rdchk("R7 pend lo read-only", 19, m_pend[31:0]);
    rdchk("R7 pend hi read-only", 18, m_pend[63:32]);
    @(negedge clk); lvl = '0; m_pend = '0;
    rdchk("R7 all fall", 19, 0);

    // R8 force
    set_pend(64'h0F0F_0001_DEAD_BEEF);
    rdchk("R8 force lo", 19, 32'hDEAD_BEEF);
    rdchk("R8 force hi", 18, 32'h0F0F_0001);
    rdchk("R8 index20 reads 0", 20, 0);
    rdchk("R8 index21 reads 0", 21, 0);

    // R9 active views and constants
    set_en('1);
    set_ty(64'hF0F0_0000_00FF_FF00);
    set_pend(64'h1234_5678_9ABC_DEF0);
    e = 32'(m_pend[63:32] & ~m_ty[63:32]); rdchk("R9 normal hi", 22, e);
    e = 32'(m_pend[31:0] & ~m_ty[31:0]);   rdchk("R9 normal lo", 23, e);
    e = 32'(m_pend[63:32] & m_ty[63:32]);  rdchk("R9 fast hi", 24, e);
    e = 32'(m_pend[31:0] & m_ty[31:0]);    rdchk("R9 fast lo", 25, e);
    rdchk("R9 const", 64, 32'd4);
    rdchk("R9 unlisted", 30, 0);
    rdchk("R9 unlisted", 26, 0);

    // R10 drain normal vector
    set_ty('0);
    set_en(64'hFFFF_FFFF_0000_FFFF);
    set_pend('1);
    for (int it = 0; it < 70; it++) begin
      e = exp_nvec(); rd(16, g); chk("R10 nvec drain", g, e);
      if (e == NONE) break;
      m_pend[e[21:16]] = 1'b0;
    end
    rdchk("R10 disabled stay pending", 19, 32'hFFFF_0000);
    set_en('1);
    set_pend(64'h8000_0000_0000_0001);
    for (int it = 0; it < 4; it++) begin
      e = exp_nvec(); rd(16, g); chk("R10 nvec pair", g, e);
      if (e == NONE) break;
      m_pend[e[21:16]] = 1'b0;
    end

    // R11 drain fast vector
    set_ty('1);
    set_pend(64'h8421_0000_0000_1000);
    rdchk("R11 normal vec empty", 16, NONE);
    chk("R12 fast out high", 32'(irq_f), 1);
    for (int it = 0; it < 8; it++) begin
      e = exp_fvec(); rd(17, g); chk("R11 fvec drain", g, e);
      if (e == NONE) break;
      m_pend[e[5:0]] = 1'b0;
    end
    chk("R12 fast out low", 32'(irq_f), 0);

    // R12 / R13 mask vs priority sweep on source 0
    set_ty('0);
    set_pend(64'h1);
    for (int p = 0; p < 16; p++) begin
      m_pr[0] = 4'(p);
      for (int k = 1; k < 8; k++) m_pr[k] = '0;
      wr(15, pword(0));
      for (int m = 0; m < 32; m++) begin
        wr(1, 32'(m));
        e = (m == 31) ? 1 : ((p > m) ? 1 : 0);
        chk("R13 normal out", 32'(irq_n), e);
      end
    end
    set_pend('0);
    chk("R13 nothing active", 32'(irq_n), 0);
    set_pend(64'h1);
    set_ty(64'h1);
    chk("R12 fast on", 32'(irq_f), 1);
    chk("R13 fast not normal", 32'(irq_n), 0);
    wr(3, 0); m_en[0] = 1'b0;
    chk("R12 disabled fast", 32'(irq_f), 0);

    // R14 acknowledge against same-cycle level rise
    set_ty('0); set_en('1);
    m_pr[0] = '0; wr(15, pword(0));
    set_pend(64'h20);
    @(negedge clk);
    idx = 10'd16; re = 1'b1; lvl[5] = 1'b1; lvl[6] = 1'b1;
    #1 g = rdata;
    chk("R14 vec during collision", g, (32'd5 << 16) | 32'(m_pr[5]));
    @(negedge clk); re = 1'b0;
    rdchk("R14 ack wins, neighbour set", 19, 32'h40);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule